// File: doc/BRIEF.md
# Watchdog Timer with Non-Maskable Interrupt Output

This block is a supervision timer. It runs a binary counter that software has to restart every so often by writing one specific byte to a kick register. If software fails to do this, the counter reaches the end of its period. The block then raises one of two requests: a single-cycle non-maskable interrupt request, or a single-cycle reset request for the system reset controller. A bit in the mode register chooses which one.

Every overflow also pulls an active-high status pin low. The pin stays low until the correct kick byte arrives. An overflow in interrupt mode also sets a sticky cause bit. The interrupt handler can read this bit to tell the watchdog apart from the other non-maskable interrupt sources. A parameter sets how the cause bit is cleared: either by writing a one to it, or as a side effect of reading it.

Software reaches the block through a small byte-wide register port. The port has three registers: mode, kick and cause. A three-bit field in the mode register picks the period, from 2^BASE_EXP up to 2^(BASE_EXP+7) clock cycles.

Top module: `wdt_nmi_top`

## Requirements
- R1: After a synchronous reset, wd_pin is 1, nmi_req and reset_req are 0, the counter is disabled, and the mode register and cause register both read 0x00.
- R2: The mode register sits at address 0. Bit 7 is the enable, bits 6:4 are the period select, and bit 0 is the action select (0 = interrupt, 1 = reset). A read returns the last value written in those bits and zeros in bits 3:1.
- R3: While enabled, an overflow occurs 2^(BASE_EXP+select) clock edges after the edge that set the enable from a zero count, or after the edge that accepted a valid kick.
- R4: In interrupt mode, an overflow drives nmi_req high for exactly one cycle, and reset_req stays 0.
- R5: In reset mode, an overflow drives reset_req high for exactly one cycle, nmi_req stays 0, and the cause bit is not set.
- R6: wd_pin goes low in the same cycle as the overflow pulse. It stays low until a valid kick is accepted.
- R7: Writing 0x4E to address 1 zeroes the counter and sets wd_pin high on that edge. If this write lands on the edge where an overflow would happen, the kick wins and no pulse is produced. Any other value written to address 1 changes neither the count nor the pin.
- R8: While the enable bit is 0, the counter holds its value. Setting the enable again resumes counting from the held value.
- R9: Bit 0 of the cause register (address 2) is set on each interrupt-mode overflow and stays set. When RD_CLR is 0, writing 1 to that bit clears it.
- R10: When RD_CLR is 1, reading address 2 returns the cause bit and then clears it, and writes to address 2 are ignored.
- R11: Read data is registered. It is valid in the cycle after bus_rd, and address 1 reads as 0x00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| nmi_req | output | 1 | One-cycle non-maskable interrupt request |
| reset_req | output | 1 | One-cycle reset request |
| wd_pin | output | 1 | Watchdog status pin, low after overflow |

## Verification
The bench times each overflow to the exact edge for several period selects in both action modes. An off-by-one in the terminal compare would show up as a period of 2^N±1.

It writes near-miss kick bytes to confirm they neither restart the count nor raise the pin. It also places a valid kick on the exact terminal edge; a design that let the overflow win would pulse there.

It pauses the count with the enable bit and then resumes it. A design that cleared the count on disable would show a full period instead of the remainder.

It also reads the cause bit twice under both clear policies. This catches a read-to-clear that fires under the write-one policy, and a cause bit that gets set in reset mode.

// File: rtl/wdt_nmi_pkg.sv
package wdt_nmi_pkg;

    // Width of the period-select field; the period range spans 2^SEL_W steps
    localparam int SEL_W = 3;
    localparam int MAX_SEL = (1 << SEL_W) - 1;

    // Byte that restarts the counter and restores the status pin
    localparam logic [7:0] KICK_CODE = 8'h4E;

    typedef enum logic [1:0] {
        A_MODE  = 2'd0,
        A_KICK  = 2'd1,
        A_CAUSE = 2'd2,
        A_RSVD  = 2'd3
    } reg_addr_e;

    typedef enum logic {
        ACT_IRQ   = 1'b0,
        ACT_RESET = 1'b1
    } action_e;

    typedef struct packed {
        logic             en;
        logic [SEL_W-1:0] sel;
        action_e          act;
    } mode_t;

    // Overflow event as seen by the output stage
    typedef struct packed {
        logic    fire;
        action_e act;
    } ovf_evt_t;

    function automatic mode_t unpack_mode(input logic [7:0] b);
        mode_t m;
        m.en  = b[7];
        m.sel = b[6:4];
        m.act = action_e'(b[0]);
        return m;
    endfunction

    function automatic logic [7:0] pack_mode(input mode_t m);
        return {m.en, m.sel, 3'b000, m.act};
    endfunction

endpackage

// File: rtl/wdt_regs.sv
module wdt_regs
    import wdt_nmi_pkg::*;
#(
    parameter bit RD_CLR = 1'b0
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       wr_en,
    input  logic       rd_en,
    input  logic [1:0] addr,
    input  logic [7:0] wdata,
    input  logic       cause_set,
    output mode_t      mode,
    output logic       kick,
    output logic [7:0] rdata
);

    reg_addr_e ra;
    logic      cause_q;
    logic      cause_clr;
    mode_t     mode_q;

    always_comb ra = reg_addr_e'(addr);

    // A kick only counts with the exact code
    always_comb kick = wr_en && (ra == A_KICK) && (wdata == KICK_CODE);

    generate
        if (RD_CLR) begin : g_read_clear
            assign cause_clr = rd_en && (ra == A_CAUSE);
        end else begin : g_write_one_clear
            assign cause_clr = wr_en && (ra == A_CAUSE) && wdata[0];
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q  <= '0;
            cause_q <= 1'b0;
            rdata   <= '0;
        end else begin
            if (wr_en && (ra == A_MODE))
                mode_q <= unpack_mode(wdata);
            // A new cause wins over a clear in the same cycle
            if (cause_set)
                cause_q <= 1'b1;
            else if (cause_clr)
                cause_q <= 1'b0;
            if (rd_en) begin
                case (ra)
                    A_MODE:  rdata <= pack_mode(mode_q);
                    A_CAUSE: rdata <= {7'b0, cause_q};
                    default: rdata <= 8'h00;
                endcase
            end
        end
    end

    assign mode = mode_q;

    // R9
    cause_set_chk: assert property (@(posedge clk) disable iff (rst)
        cause_set |=> cause_q);

    // R9
    cause_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (cause_q && !cause_clr) |=> cause_q);

    // R2
    mode_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !(wr_en && (addr == 2'd0)) |=> $stable(mode_q));

endmodule

// File: rtl/wdt_counter.sv
module wdt_counter
    import wdt_nmi_pkg::*;
#(
    parameter int BASE_EXP = 15
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic [SEL_W-1:0] sel,
    input  logic             kick,
    output logic             ovf
);

    localparam int CNT_W = BASE_EXP + MAX_SEL;

    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] term_mask;
    logic             at_term;

    // Mask of BASE_EXP+sel ones: the count value on the last cycle of a period
    always_comb term_mask = {CNT_W{1'b1}} >> (MAX_SEL - int'(sel));
    always_comb at_term   = ((cnt & term_mask) == term_mask);
    always_comb ovf       = en && at_term && !kick;

    always_ff @(posedge clk) begin
        if (rst)
            cnt <= '0;
        else if (kick || ovf)
            cnt <= '0;
        else if (en)
            cnt <= cnt + 1'b1;
    end

    // R8
    hold_when_off_chk: assert property (@(posedge clk) disable iff (rst)
        (!en && !kick) |=> $stable(cnt));

    // R7
    kick_zero_chk: assert property (@(posedge clk) disable iff (rst)
        kick |=> (cnt == '0));

endmodule

// File: rtl/wdt_event.sv
module wdt_event
    import wdt_nmi_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  ovf_evt_t evt,
    input  logic     kick,
    output logic     cause_set,
    output logic     nmi,
    output logic     rreq,
    output logic     pin
);

    always_comb cause_set = evt.fire && (evt.act == ACT_IRQ);

    always_ff @(posedge clk) begin
        if (rst) begin
            nmi  <= 1'b0;
            rreq <= 1'b0;
            pin  <= 1'b1;
        end else begin
            nmi  <= evt.fire && (evt.act == ACT_IRQ);
            rreq <= evt.fire && (evt.act == ACT_RESET);
            if (evt.fire)
                pin <= 1'b0;
            else if (kick)
                pin <= 1'b1;
        end
    end

    // R6
    pin_low_chk: assert property (@(posedge clk) disable iff (rst)
        evt.fire |=> !pin);

    // R6
    pin_stays_low_chk: assert property (@(posedge clk) disable iff (rst)
        (!pin && !kick && !evt.fire) |=> !pin);

    // R7
    pin_restore_chk: assert property (@(posedge clk) disable iff (rst)
        kick |=> pin);

    // R4
    nmi_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        nmi |=> !nmi);

    // R5
    rreq_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        rreq |=> !rreq);

    // R4
    req_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(nmi && rreq));

endmodule

// File: rtl/wdt_nmi_top.sv
module wdt_nmi_top
    import wdt_nmi_pkg::*;
#(
    parameter int BASE_EXP = 15,
    parameter bit RD_CLR   = 1'b0
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       bus_wr,
    input  logic       bus_rd,
    input  logic [1:0] bus_addr,
    input  logic [7:0] bus_wdata,
    output logic [7:0] bus_rdata,
    output logic       nmi_req,
    output logic       reset_req,
    output logic       wd_pin
);

    mode_t    mode;
    logic     kick;
    logic     ovf;
    logic     cause_set;
    ovf_evt_t evt;

    wdt_regs #(.RD_CLR(RD_CLR)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (bus_wr),
        .rd_en     (bus_rd),
        .addr      (bus_addr),
        .wdata     (bus_wdata),
        .cause_set (cause_set),
        .mode      (mode),
        .kick      (kick),
        .rdata     (bus_rdata)
    );

    wdt_counter #(.BASE_EXP(BASE_EXP)) u_cnt (
        .clk  (clk),
        .rst  (rst),
        .en   (mode.en),
        .sel  (mode.sel),
        .kick (kick),
        .ovf  (ovf)
    );

    always_comb begin
        evt.fire = ovf;
        evt.act  = mode.act;
    end

    wdt_event u_evt (
        .clk       (clk),
        .rst       (rst),
        .evt       (evt),
        .kick      (kick),
        .cause_set (cause_set),
        .nmi       (nmi_req),
        .rreq      (reset_req),
        .pin       (wd_pin)
    );

    // R5
    reset_mode_no_nmi_chk: assert property (@(posedge clk) disable iff (rst)
        (ovf && mode.act == ACT_RESET) |=> (reset_req && !nmi_req));

    // R7
    kick_blocks_ovf_chk: assert property (@(posedge clk) disable iff (rst)
        kick |=> (!nmi_req && !reset_req));

endmodule

// File: tb/wdt_nmi_top_tb_top.sv
module wdt_nmi_top_tb_top;

    localparam int BASE = 4;
    localparam int NVEC = 4;
    // {sel[2:0], action}
    localparam logic [3:0] VEC [NVEC] = '{
        {3'd0, 1'b0}, {3'd1, 1'b1}, {3'd2, 1'b0}, {3'd0, 1'b1}
    };

    logic       clk = 1'b0;
    logic       rst;
    logic       bus_wr, bus_rd;
    logic [1:0] bus_addr;
    logic [7:0] bus_wdata;
    logic [7:0] rdata_a, rdata_b;
    logic       nmi_a, nmi_b, rreq_a, rreq_b, pin_a, pin_b;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    wdt_nmi_top #(.BASE_EXP(BASE), .RD_CLR(1'b0)) dut_i (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(rdata_a),
        .nmi_req(nmi_a), .reset_req(rreq_a), .wd_pin(pin_a));

    wdt_nmi_top #(.BASE_EXP(BASE), .RD_CLR(1'b1)) dut_rc_i (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(rdata_b),
        .nmi_req(nmi_b), .reset_req(rreq_b), .wd_pin(pin_b));

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk);
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a);
        bus_rd = 1'b1; bus_addr = a;
        @(posedge clk);
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic wait_ovf(output int n);
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (!(nmi_a || rreq_a) && n < 5000);
    endtask

    task automatic cleanup();
        wr(2'd0, 8'h00);
        wr(2'd1, 8'h4E);
        wr(2'd2, 8'h01);
        rd(2'd2);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int n;
        bit seen;
        rst = 1'b1; bus_wr = 1'b0; bus_rd = 1'b0; bus_addr = '0; bus_wdata = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        chk("R1 pin", pin_a, 1);
        chk("R1 nmi", nmi_a, 0);
        chk("R1 rreq", rreq_a, 0);
        rd(2'd0);
        chk("R1 mode", rdata_a, 0);
        rd(2'd2);
        chk("R1 cause", rdata_a, 0);

        // Table walk: R3 R4 R5 R6 R9
        for (int v = 0; v < NVEC; v++) begin
            logic [2:0] s;
            logic       act;
            s   = VEC[v][3:1];
            act = VEC[v][0];
            wr(2'd0, {1'b1, s, 3'b000, act});
            wait_ovf(n);
            chk("R3 period", n, 1 << (BASE + int'(s)));
            chk("R4 nmi level", nmi_a, int'(!act));
            chk("R5 rreq level", rreq_a, int'(act));
            chk("R5 rreq other policy", rreq_b, int'(act));
            chk("R6 pin low", pin_a, 0);
            @(negedge clk);
            chk("R4 R5 pulse ends", int'(nmi_a || rreq_a), 0);
            chk("R6 pin held", pin_a, 0);
            rd(2'd2);
            chk("R9 cause", rdata_a[0], int'(!act));
            wr(2'd0, 8'h00);
            wr(2'd1, 8'h4E);
            chk("R7 pin restored", pin_a, 1);
            wr(2'd2, 8'h01);
            rd(2'd2);
            chk("R9 w1c", rdata_a[0], 0);
        end

        // R7 wrong code ignored
        wr(2'd0, 8'h80);
        repeat (8) @(negedge clk);
        wr(2'd1, 8'h4D);
        wait_ovf(n);
        chk("R7 bad code keeps count", n, 7);
        wr(2'd1, 8'h00);
        chk("R7 bad code keeps pin low", pin_a, 0);
        repeat (3) @(negedge clk);
        wr(2'd1, 8'h4E);
        chk("R7 good code raises pin", pin_a, 1);
        wait_ovf(n);
        chk("R7 restart period", n, 16);
        cleanup();

        // R8 disable holds count
        wr(2'd0, 8'h80);
        repeat (5) @(negedge clk);
        wr(2'd0, 8'h00);
        seen = 1'b0;
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            if (nmi_a || rreq_a || !pin_a) seen = 1'b1;
        end
        chk("R8 no overflow while off", seen, 0);
        wr(2'd0, 8'h80);
        wait_ovf(n);
        chk("R8 resume from held", n, 10);
        cleanup();

        // R7 kick on the terminal edge wins
        wr(2'd0, 8'h80);
        repeat (15) @(negedge clk);
        wr(2'd1, 8'h4E);
        chk("R7 kick wins nmi", nmi_a, 0);
        chk("R7 kick wins pin", pin_a, 1);
        wait_ovf(n);
        chk("R7 period after kick", n, 16);
        wr(2'd0, 8'h00);

        // R10 read-to-clear vs R9 write-one-clear
        rd(2'd2);
        chk("R9 cause set w1c", rdata_a[0], 1);
        chk("R10 cause set rc", rdata_b[0], 1);
        rd(2'd2);
        chk("R9 read keeps cause", rdata_a[0], 1);
        chk("R10 read cleared cause", rdata_b[0], 0);
        wr(2'd2, 8'h01);
        rd(2'd2);
        chk("R9 w1c cleared", rdata_a[0], 0);
        wr(2'd1, 8'h4E);

        // R2 mode readback, R11 kick address reads zero
        wr(2'd0, 8'hB1);
        rd(2'd0);
        chk("R2 mode readback", rdata_a, 8'hB1);
        wr(2'd0, 8'h7F);
        rd(2'd0);
        chk("R2 reserved bits zero", rdata_a, 8'h71);
        wr(2'd0, 8'h00);
        rd(2'd1);
        chk("R11 kick reads zero", rdata_a, 0);
        chk("R11 kick reads zero rc", rdata_b, 0);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule